// File: doc/BRIEF.md
# Link Pulse Burst Page Receiver

This block turns a stream of detected link pulses into 16-bit pages. Each burst starts with a clock pulse. Every later clock pulse closes one bit slot. A pulse that arrives near the middle of a slot marks that bit as 1. A slot with no such pulse gives a 0. When the last clock pulse of a burst is accepted, the block presents the assembled page with a one-cycle strobe.

A burst is aborted, and an error strobe raised, when either of these happens:
- a pulse lands outside both timing windows;
- a slot carries a second data pulse;
- the next clock pulse fails to arrive in time.

A separate tracker counts how many identical pages have arrived in a row without an intervening error. It raises a consistency flag once the required number is reached, so negotiation logic can trust the advertised word.

The input is a single-bit pulse-detect signal that is already synchronised to the system clock and lasts one cycle per pulse. All timing windows are parameters counted in system-clock ticks.

Top module: `flp_page_rx`

## Requirements
- R1: While reset is asserted, `page_valid_o`, `err_o` and `consistent_o` are 0 and `page_o` is all zeros.
- R2: A pulse arriving DATA_MIN to DATA_MAX ticks (inclusive) after the last accepted clock pulse marks the current bit as 1. A slot without such a pulse yields 0.
- R3: The first bit slot of a burst becomes bit 0 of `page_o`. Later slots fill bits in increasing order up to bit 15.
- R4: A pulse arriving CLK_MIN to CLK_MAX ticks (inclusive) after the previous clock pulse is accepted as a clock pulse. When the 17th clock pulse of a burst is accepted, `page_valid_o` is high for exactly one cycle, in the cycle after that pulse's input cycle, and `page_o` carries the new page in that cycle.
- R5: A pulse inside a burst that falls in neither window raises `err_o` for one cycle, in the cycle after the pulse. No `page_valid_o` is issued for that burst.
- R6: If no pulse has arrived by CLK_MAX ticks after the last clock pulse, the burst aborts. `err_o` is high in the cycle after the tick-CLK_MAX cycle.
- R7: A second data-window pulse within the same bit slot aborts the burst with `err_o`.
- R8: `page_o` changes only together with `page_valid_o`. It holds its value through error bursts and idle time.
- R9: `consistent_o` rises one cycle after the `page_valid_o` of the third consecutive identical page. It is still 0 after the second.
- R10: A valid page that differs from the previous valid page restarts the match count at one, so `consistent_o` drops the cycle after it.
- R11: An error burst clears the match count. `consistent_o` is 0 in the cycle after `err_o`, and the following page counts as the first of a new run.
- R12: After a completed or aborted burst, the block is idle. The next pulse starts a new burst as its first clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | Synchronised one-cycle link pulse detect |
| page_valid_o | output | 1 | One-cycle strobe for a completed page |
| page_o | output | PAGE_BITS | Last page received, held until the next one |
| err_o | output | 1 | One-cycle strobe for an aborted burst |
| consistent_o | output | 1 | Required number of identical pages seen in a row |

## Verification
The assertions assume that `pulse_i` is already synchronous and high for a single cycle per detected pulse. They also assume the data window lies strictly below the clock window, so no tick offset can belong to both. The stimulus raises `pulse_i` for one cycle at a time, at chosen offsets from the last clock pulse. It sweeps every offset from 1 up to CLK_MAX, plus the full grid of data and clock offsets inside the windows, on a configuration whose windows are only a few ticks wide.

// File: rtl/flp_rx_pkg.sv
package flp_rx_pkg;

   typedef enum logic [1:0] {
      PC_NONE  = 2'd0,
      PC_DATA  = 2'd1,
      PC_CLOCK = 2'd2,
      PC_STRAY = 2'd3
   } pulse_class_e;

   typedef enum logic {
      RX_IDLE  = 1'b0,
      RX_BURST = 1'b1
   } rx_state_e;

endpackage

// File: rtl/flp_slot_timer.sv
module flp_slot_timer
   import flp_rx_pkg::*;
#(
   parameter int DATA_MIN = 5,
   parameter int DATA_MAX = 7,
   parameter int CLK_MIN  = 11,
   parameter int CLK_MAX  = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         restart_i,
   input  logic         pulse_i,
   output pulse_class_e cls_o,
   output logic         timeout_o
);
   localparam int TW = $clog2(CLK_MAX + 1);
   localparam logic [TW-1:0] DMIN_T = TW'(DATA_MIN);
   localparam logic [TW-1:0] DMAX_T = TW'(DATA_MAX);
   localparam logic [TW-1:0] CMIN_T = TW'(CLK_MIN);
   localparam logic [TW-1:0] CMAX_T = TW'(CLK_MAX);

   logic [TW-1:0] ticks;

   // ticks equals the number of cycles since the last accepted clock pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks <= '0;
      end else if (restart_i) begin
         ticks <= TW'(1);
      end else if (!run_i) begin
         ticks <= '0;
      end else if (ticks != CMAX_T) begin
         ticks <= ticks + TW'(1);
      end
   end

   logic in_data_win;
   logic in_clk_win;

   always_comb begin
      in_data_win = (ticks >= DMIN_T) && (ticks <= DMAX_T);
      in_clk_win  = (ticks >= CMIN_T) && (ticks <= CMAX_T);
      if (!pulse_i) begin
         cls_o = PC_NONE;
      end else if (in_data_win) begin
         cls_o = PC_DATA;
      end else if (in_clk_win) begin
         cls_o = PC_CLOCK;
      end else begin
         cls_o = PC_STRAY;
      end
      timeout_o = run_i && !pulse_i && (ticks == CMAX_T);
   end

   // R2: a running slot never reports a window hit before the data window opens
   a_r2_no_early_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && pulse_i && (ticks < DMIN_T)) |-> (cls_o == PC_STRAY));

endmodule

// File: rtl/flp_burst_fsm.sv
module flp_burst_fsm
   import flp_rx_pkg::*;
#(
   parameter int PAGE_BITS = 16,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pulse_i,
   input  pulse_class_e         cls_i,
   input  logic                 timeout_i,
   output logic                 run_o,
   output logic                 restart_o,
   output logic                 page_valid_o,
   output logic [PAGE_BITS-1:0] page_o,
   output logic                 err_o
);
   localparam int CLOCKS = PAGE_BITS + 1;
   localparam int CW     = $clog2(CLOCKS + 1);
   localparam int IW     = $clog2(PAGE_BITS);
   localparam logic [CW-1:0] LAST_CNT = CW'(PAGE_BITS);

   rx_state_e            state;
   logic [CW-1:0]        clk_cnt;
   logic                 data_seen;
   logic [PAGE_BITS-1:0] acc;
   logic [IW-1:0]        bit_idx;
   logic [PAGE_BITS-1:0] merged;
   logic                 last_clock;
   logic                 abort;

   generate
      if (LSB_FIRST) begin : g_lsb_first
         always_comb bit_idx = IW'(clk_cnt - CW'(1));
      end else begin : g_msb_first
         always_comb bit_idx = IW'(LAST_CNT - clk_cnt);
      end
   endgenerate

   always_comb begin
      merged     = acc | ({{(PAGE_BITS-1){1'b0}}, data_seen} << bit_idx);
      last_clock = (clk_cnt == LAST_CNT);
      run_o      = (state == RX_BURST);
      abort      = (state == RX_BURST) &&
                   ((cls_i == PC_STRAY) ||
                    ((cls_i == PC_DATA) && data_seen) ||
                    timeout_i);
      restart_o  = ((state == RX_IDLE) && pulse_i) ||
                   ((state == RX_BURST) && (cls_i == PC_CLOCK));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= RX_IDLE;
         clk_cnt      <= '0;
         data_seen    <= 1'b0;
         acc          <= '0;
         page_o       <= '0;
         page_valid_o <= 1'b0;
         err_o        <= 1'b0;
      end else begin
         page_valid_o <= 1'b0;
         err_o        <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (pulse_i) begin
                  state     <= RX_BURST;
                  clk_cnt   <= CW'(1);
                  data_seen <= 1'b0;
                  acc       <= '0;
               end
            end
            RX_BURST: begin
               if (abort) begin
                  err_o <= 1'b1;
                  state <= RX_IDLE;
               end else if (cls_i == PC_DATA) begin
                  data_seen <= 1'b1;
               end else if (cls_i == PC_CLOCK) begin
                  acc       <= merged;
                  data_seen <= 1'b0;
                  clk_cnt   <= clk_cnt + CW'(1);
                  if (last_clock) begin
                     page_o       <= merged;
                     page_valid_o <= 1'b1;
                     state        <= RX_IDLE;
                  end
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R4: the page strobe lasts a single cycle
   a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      page_valid_o |=> !page_valid_o);

   // R4: the clock count never passes the last slot while a burst runs
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> (clk_cnt <= LAST_CNT));

   // R5: an aborted burst never also reports a page
   a_r5_valid_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(page_valid_o && err_o));

   // R5: a stray pulse in a burst leads to an error strobe
   a_r5_stray_err: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && (cls_i == PC_STRAY)) |=> err_o);

   // R6: an expired clock window leads to an error strobe
   a_r6_timeout_err: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && timeout_i) |=> err_o);

   // R8: the page output moves only with its strobe
   a_r8_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !page_valid_o |-> $stable(page_o));

   // R12: after any finished burst the block is waiting for a new first pulse
   a_r12_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
      (page_valid_o || err_o) |-> !run_o);

endmodule

// File: rtl/flp_match_tracker.sv
module flp_match_tracker #(
   parameter int PAGE_BITS   = 16,
   parameter int REQ_MATCHES = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 page_valid_i,
   input  logic [PAGE_BITS-1:0] page_i,
   input  logic                 err_i,
   output logic                 consistent_o
);
   localparam int MW = $clog2(REQ_MATCHES + 1);
   localparam logic [MW-1:0] REQ_T = MW'(REQ_MATCHES);

   generate
      if (REQ_MATCHES == 1) begin : g_single
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            hit_q <= 1'b0;
            else if (err_i)        hit_q <= 1'b0;
            else if (page_valid_i) hit_q <= 1'b1;
         end
         assign consistent_o = hit_q;
      end else begin : g_counted
         logic [MW-1:0]        run_len;
         logic [PAGE_BITS-1:0] last_page;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_len   <= '0;
               last_page <= '0;
            end else if (err_i) begin
               run_len <= '0;
            end else if (page_valid_i) begin
               last_page <= page_i;
               if ((run_len != '0) && (page_i == last_page)) begin
                  if (run_len != REQ_T) run_len <= run_len + MW'(1);
               end else begin
                  run_len <= MW'(1);
               end
            end
         end

         assign consistent_o = (run_len == REQ_T);

         // R10: a page unlike the stored one drops the flag next cycle
         a_r10_change_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (page_valid_i && !err_i && (page_i != last_page)) |=> !consistent_o);
      end
   endgenerate

   // R11: an error strobe clears the flag next cycle
   a_r11_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
      err_i |=> !consistent_o);

   // R9: the flag only ever rises right after an accepted page
   a_r9_rise_after_page: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(consistent_o) |-> $past(page_valid_i));

endmodule

// File: rtl/flp_page_rx.sv
module flp_page_rx #(
   parameter int PAGE_BITS   = 16,
   parameter int DATA_MIN    = 6875,
   parameter int DATA_MAX    = 8625,
   parameter int CLK_MIN     = 13875,
   parameter int CLK_MAX     = 17375,
   parameter int REQ_MATCHES = 3,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pulse_i,
   output logic                 page_valid_o,
   output logic [PAGE_BITS-1:0] page_o,
   output logic                 err_o,
   output logic                 consistent_o
);
   import flp_rx_pkg::*;

   generate
      if (PAGE_BITS < 2) begin : g_chk_bits
         $error("PAGE_BITS must be at least 2");
      end
      if (DATA_MIN < 1 || DATA_MAX < DATA_MIN) begin : g_chk_data
         $error("data window must be non-empty and start after tick 0");
      end
      if (CLK_MIN <= DATA_MAX || CLK_MAX < CLK_MIN) begin : g_chk_clk
         $error("clock window must be non-empty and lie above the data window");
      end
      if (REQ_MATCHES < 1) begin : g_chk_req
         $error("REQ_MATCHES must be at least 1");
      end
   endgenerate

   pulse_class_e cls;
   logic         timeout;
   logic         run;
   logic         restart;

   flp_slot_timer #(
      .DATA_MIN (DATA_MIN),
      .DATA_MAX (DATA_MAX),
      .CLK_MIN  (CLK_MIN),
      .CLK_MAX  (CLK_MAX)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .restart_i (restart),
      .pulse_i   (pulse_i),
      .cls_o     (cls),
      .timeout_o (timeout)
   );

   flp_burst_fsm #(
      .PAGE_BITS (PAGE_BITS),
      .LSB_FIRST (LSB_FIRST)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .pulse_i      (pulse_i),
      .cls_i        (cls),
      .timeout_i    (timeout),
      .run_o        (run),
      .restart_o    (restart),
      .page_valid_o (page_valid_o),
      .page_o       (page_o),
      .err_o        (err_o)
   );

   flp_match_tracker #(
      .PAGE_BITS   (PAGE_BITS),
      .REQ_MATCHES (REQ_MATCHES)
   ) u_match (
      .clk          (clk),
      .rst_n        (rst_n),
      .page_valid_i (page_valid_o),
      .page_i       (page_o),
      .err_i        (err_o),
      .consistent_o (consistent_o)
   );

   // R1: outputs are quiet during reset
   always_comb begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (!page_valid_o && !err_o && !consistent_o);
      end
   end

endmodule

// File: tb/flp_page_rx_bench.sv
`timescale 1ns/1ps
module flp_page_rx_bench;
   localparam int PB   = 16;
   localparam int DMIN = 5;
   localparam int DMAX = 7;
   localparam int CMIN = 11;
   localparam int CMAX = 14;
   localparam int REQ  = 3;
   localparam int DNOM = 6;
   localparam int CNOM = 12;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic          pulse = 1'b0;
   logic          page_valid;
   logic [PB-1:0] page;
   logic          err;
   logic          consistent;

   int total = 0;
   int bad = 0;
   int pv_seen = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   flp_page_rx #(
      .PAGE_BITS   (PB),
      .DATA_MIN    (DMIN),
      .DATA_MAX    (DMAX),
      .CLK_MIN     (CMIN),
      .CLK_MAX     (CMAX),
      .REQ_MATCHES (REQ),
      .LSB_FIRST   (1'b1)
   ) u_flp_page_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .pulse_i      (pulse),
      .page_valid_o (page_valid),
      .page_o       (page),
      .err_o        (err),
      .consistent_o (consistent)
   );

   always @(negedge clk) if (rst_n && page_valid) pv_seen++;

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one call = one clock edge; the design samples p at that edge
   task automatic step(input logic p);
      pulse = p;
      @(posedge clk);
      #1;
      pulse = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) step(1'b0);
   endtask

   task automatic send_burst(input logic [PB-1:0] pg, input int doff, input int coff);
      step(1'b1);
      for (int b = 0; b < PB; b++) begin
         for (int c = 1; c <= coff; c++) begin
            step(((c == doff) && pg[b]) || (c == coff));
         end
      end
   endtask

   task automatic abort_at(input int k);
      step(1'b1);
      for (int c = 1; c < k; c++) step(1'b0);
      step(1'b1);
   endtask

   task automatic page_and_flag(input logic [PB-1:0] pg, input logic exp_flag, input string req);
      send_burst(pg, DNOM, CNOM);
      check(req, 32'(page_valid), 32'd1);
      check(req, 32'(page), 32'(pg));
      step(1'b0);
      check(req, 32'(consistent), 32'(exp_flag));
      idle(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [PB-1:0] pats [5];
      logic [PB-1:0] held;
      int pv0;
      pats[0] = 16'h0001;
      pats[1] = 16'h8000;
      pats[2] = 16'hFFFF;
      pats[3] = 16'h0000;
      pats[4] = 16'h5A3C;

      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 page_valid", 32'(page_valid), 32'd0);
      check("R1 err", 32'(err), 32'd0);
      check("R1 consistent", 32'(consistent), 32'd0);
      check("R1 page", 32'(page), 32'd0);
      rst_n = 1'b1;
      idle(2);

      // R2 R3 R4: fixed patterns, bit 0 from first slot
      for (int i = 0; i < 5; i++) begin
         send_burst(pats[i], DNOM, CNOM);
         check("R3 valid", 32'(page_valid), 32'd1);
         check("R3 page", 32'(page), 32'(pats[i]));
         check("R4 no err", 32'(err), 32'd0);
         step(1'b0);
         check("R4 strobe one cycle", 32'(page_valid), 32'd0);
         check("R8 page held", 32'(page), 32'(pats[i]));
         idle(3);
      end

      // R2 R4: full grid of in-window data and clock offsets
      for (int d = DMIN; d <= DMAX; d++) begin
         for (int c = CMIN; c <= CMAX; c++) begin
            logic [PB-1:0] pg;
            pg = PB'((d * 4663 + c * 1031) ^ 16'h2B91);
            send_burst(pg, d, c);
            check("R2 grid valid", 32'(page_valid), 32'd1);
            check("R2 grid page", 32'(page), 32'(pg));
            idle(2);
         end
      end

      // R5: every second-pulse offset outside both windows
      for (int k = 1; k <= CMAX; k++) begin
         if ((k < DMIN) || ((k > DMAX) && (k < CMIN))) begin
            held = page;
            pv0 = pv_seen;
            abort_at(k);
            check("R5 err", 32'(err), 32'd1);
            check("R5 no valid", 32'(page_valid), 32'd0);
            idle(3);
            check("R5 no strobe", 32'(pv_seen), 32'(pv0));
            check("R8 page kept", 32'(page), 32'(held));
         end
      end

      // R5: abort in the middle of a burst
      held = page;
      pv0 = pv_seen;
      step(1'b1);
      for (int b = 0; b < 5; b++)
         for (int c = 1; c <= CNOM; c++) step(c == CNOM);
      for (int c = 1; c < 9; c++) step(1'b0);
      step(1'b1);
      check("R5 mid err", 32'(err), 32'd1);
      idle(3 * CNOM);
      check("R5 mid no strobe", 32'(pv_seen), 32'(pv0));
      check("R8 mid page kept", 32'(page), 32'(held));

      // R6: missing clock pulse
      step(1'b1);
      repeat (CMAX - 1) step(1'b0);
      check("R6 not yet", 32'(err), 32'd0);
      step(1'b0);
      check("R6 timeout err", 32'(err), 32'd1);
      idle(3);

      // R7: two data pulses in one slot
      step(1'b1);
      repeat (DMIN - 1) step(1'b0);
      step(1'b1);
      check("R7 first data ok", 32'(err), 32'd0);
      step(1'b1);
      check("R7 double data err", 32'(err), 32'd1);
      idle(3);

      // R12: a burst right after an abort is received whole
      abort_at(2);
      check("R12 abort", 32'(err), 32'd1);
      send_burst(16'h3C69, DNOM, CNOM);
      check("R12 valid", 32'(page_valid), 32'd1);
      check("R12 page", 32'(page), 32'h3C69);
      idle(3);

      // R9 R10 R11: consistency tracking
      abort_at(2);
      step(1'b0);
      check("R11 cleared", 32'(consistent), 32'd0);
      idle(2);
      page_and_flag(16'hBEEF, 1'b0, "R9 first copy");
      page_and_flag(16'hBEEF, 1'b0, "R9 second copy");
      page_and_flag(16'hBEEF, 1'b1, "R9 third copy");
      page_and_flag(16'hBEEF, 1'b1, "R9 fourth copy");
      page_and_flag(16'h1234, 1'b0, "R10 changed page");
      page_and_flag(16'h1234, 1'b0, "R10 second copy");
      page_and_flag(16'h1234, 1'b1, "R10 third copy");
      abort_at(3);
      check("R11 err", 32'(err), 32'd1);
      step(1'b0);
      check("R11 flag dropped", 32'(consistent), 32'd0);
      check("R8 page after err", 32'(page), 32'h1234);
      idle(2);
      page_and_flag(16'h1234, 1'b0, "R11 restart count");
      page_and_flag(16'h1234, 1'b0, "R11 second after err");
      page_and_flag(16'h1234, 1'b1, "R11 third after err");

      finish_run();
   end
endmodule